// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

A down-counting timer with a small register interface driven by one-cycle write and read strobes. It runs in one of two modes. As a plain periodic timer, each time the counter reaches zero it reloads and latches a sticky event flag, which can drive a level interrupt. As a watchdog, reaching zero produces a one-cycle reset request and latches a sticky reset flag.

The reset flag is cleared only by the power-on reset. The system reset, which the watchdog's own request is meant to trigger, leaves it untouched. Boot software can therefore read it to tell a cold start from a restart caused by a timeout.

Writing 1 to the mode bit enters watchdog mode at any time. Writing 0 to that bit does nothing. The only way back to timer mode is two consecutive key writes to the disarm register, checked by a two-state unlock machine with the states `LK_IDLE` and `LK_ARMED`:
- `LK_IDLE` to `LK_ARMED` on the first key.
- `LK_ARMED` to `LK_IDLE` with an unlock on the second key.
- `LK_ARMED` to `LK_IDLE` without an unlock on a wrong word or on a write to any other register.

Top module: `wdt_dual_mode`

Register map (3-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | RELOAD | Reload value. A write also loads the counter. |
| 1 | COUNT | Current count. A write overwrites the counter. |
| 2 | CTRL | bit0 = run, bit1 = interrupt enable, bit2 = watchdog mode |
| 3 | STATUS | Event flag in bit0, other bits read 0 |
| 4 | BOOTFLAG | Reset flag in bit0, other bits read 0 |
| 5 | DISARM | Key writes; reads 0 |

## Requirements
- R1: After a power-on reset (`por_n` low at a clock edge), every register reads 0, and `irq_o` and `wdt_rst_o` are 0.
- R2: While CTRL bit0 is 1, the counter decrements by one each clock. The clock edge at which it is 0 reloads it from RELOAD. A RELOAD write sets both RELOAD and the counter, and a COUNT write sets the counter; either write takes priority over counting. A read returns, one cycle after the `rd_en` edge, the value the register held before that edge.
- R3: In timer mode (CTRL bit2 = 0), the edge at which the running counter is 0 sets the event flag, which reads as STATUS bit0; all other STATUS bits read 0.
- R4: `irq_o` is 1 exactly when the event flag and CTRL bit1 are both 1.
- R5: Writing STATUS with bit0 = 1 clears the event flag. Writing bit0 = 0 has no effect. If a clear and a zero event fall on the same edge, the flag ends up set.
- R6: In watchdog mode, the edge at which the running counter is 0 drives `wdt_rst_o` high for exactly one cycle and leaves the event flag unchanged.
- R7: The same watchdog event sets the reset flag, BOOTFLAG bit0. Writing bit0 = 1 clears it and writing 0 has no effect. A set on the same edge wins over a clear.
- R8: `sys_rst_n` low clears every register except the reset flag; `por_n` low clears it as well.
- R9: A DISARM write of 0x12345678 followed by the very next register write being a DISARM write of 0x87654321 clears CTRL bit2. Cycles without a write may lie between the two.
- R10: A wrong DISARM word, a lone second key, or any other register write between the two keys leaves CTRL bit2 unchanged and restarts the sequence.
- R11: A CTRL write sets CTRL bit2 when data bit2 = 1 and leaves it unchanged when data bit2 = 0; bit0 and bit1 always take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous; keeps the reset flag |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, registered, holds until the next read |
| irq_o | output | 1 | Timer interrupt, level |
| wdt_rst_o | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
The counter's zero event and a software write-one-to-clear of the same sticky flag can fall on one clock edge. This applies to the event flag in timer mode and to the reset flag in watchdog mode. The bench provokes the collision by writing 1 to COUNT, idling one cycle and then issuing the clear, so the clear lands on the edge where the count is 0. It judges the outcome by reading the flag back, expecting it set, and the behavioural model compares every output on every clock around that edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_BOOT   = 3'd4;
    localparam logic [ADDR_W-1:0] A_DISARM = 3'd5;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_IE  = 1;
    localparam int CTRL_WD  = 2;

    typedef enum logic [0:0] {
        LK_IDLE  = 1'b0,
        LK_ARMED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/wdt_sticky_flag.sv
module wdt_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    // R5 (event flag) and R7 (reset flag): only a clear drops the flag
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    // R5 / R7: a simultaneous set beats the clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         reload_we,
    input  logic         count_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] reload_q,
    output logic         zero_hit
);
    assign zero_hit = run_i && (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
        end else begin
            if (reload_we)
                reload_q <= wdata;
            if (reload_we || count_we)
                count_q <= wdata;
            else if (zero_hit)
                count_q <= reload_q;
            else if (run_i)
                count_q <= count_q - 1'b1;
        end
    end

    // R2: one step down per clock when running and untouched
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && count_q != '0 && !reload_we && !count_we)
        |=> count_q == $past(count_q) - 1'b1);

    // R2: zero reloads from the reload register
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && !reload_we && !count_we) |=> count_q == $past(reload_q));
endmodule

// File: rtl/wdt_unlock_fsm.sv
module wdt_unlock_fsm
    import wdt_pkg::*;
#(
    parameter int         W          = 32,
    parameter logic [W-1:0] KEY_FIRST  = 32'h1234_5678,
    parameter logic [W-1:0] KEY_SECOND = 32'h8765_4321
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         disarm_sel,
    input  logic [W-1:0] wdata,
    output logic         unlock_o
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LK_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                LK_IDLE:  state_d = (disarm_sel && wdata == KEY_FIRST) ? LK_ARMED : LK_IDLE;
                LK_ARMED: state_d = LK_IDLE;
                default:  state_d = LK_IDLE;
            endcase
        end
    end

    always_comb begin
        unlock_o = 1'b0;
        unique case (state_q)
            LK_IDLE:  unlock_o = 1'b0;
            LK_ARMED: unlock_o = wr_en && disarm_sel && (wdata == KEY_SECOND);
            default:  unlock_o = 1'b0;
        endcase
    end

    // R10: the armed state only follows a write to the disarm register
    p_armed_after_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LK_ARMED) |-> $past(wr_en && disarm_sel && wdata == KEY_FIRST));

    // R10: any write while armed ends the armed state
    p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && wr_en) |=> state_q == LK_IDLE);
endmodule

// File: rtl/wdt_dual_mode.sv
module wdt_dual_mode
    import wdt_pkg::*;
#(
    parameter int            DW         = 32,
    parameter logic [DW-1:0] KEY_FIRST  = 32'h1234_5678,
    parameter logic [DW-1:0] KEY_SECOND = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    logic          rst_n;
    logic          wr_reload, wr_count, wr_ctrl, wr_status, wr_boot, wr_disarm;
    logic          run_q, ie_q, wd_q;
    logic [DW-1:0] count_q, reload_q;
    logic          zero_hit, unlock;
    logic          evt_q, boot_q;

    assign rst_n = por_n & sys_rst_n;

    assign wr_reload = wr_en && (wr_addr == A_RELOAD);
    assign wr_count  = wr_en && (wr_addr == A_COUNT);
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_status = wr_en && (wr_addr == A_STATUS);
    assign wr_boot   = wr_en && (wr_addr == A_BOOT);
    assign wr_disarm = wr_en && (wr_addr == A_DISARM);

    wdt_counter #(.W(DW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .reload_we (wr_reload),
        .count_we  (wr_count),
        .wdata     (wr_data),
        .count_q   (count_q),
        .reload_q  (reload_q),
        .zero_hit  (zero_hit)
    );

    wdt_unlock_fsm #(.W(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .disarm_sel (wr_disarm),
        .wdata      (wr_data),
        .unlock_o   (unlock)
    );

    wdt_sticky_flag u_evt_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (zero_hit && !wd_q),
        .clr_i  (wr_status && wr_data[0]),
        .flag_q (evt_q)
    );

    // reset flag: cleared by power-on only, survives the system reset
    wdt_sticky_flag u_boot_flag (
        .clk    (clk),
        .rst_n  (por_n),
        .set_i  (zero_hit && wd_q),
        .clr_i  (wr_boot && wr_data[0]),
        .flag_q (boot_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            wd_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_q <= wr_data[CTRL_RUN];
                ie_q  <= wr_data[CTRL_IE];
                if (wr_data[CTRL_WD])
                    wd_q <= 1'b1;
            end else if (unlock) begin
                wd_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_rst_o <= 1'b0;
        else
            wdt_rst_o <= zero_hit && wd_q;
    end

    assign irq_o = evt_q & ie_q;

    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        unique case (rd_addr)
            A_RELOAD: rd_mux = reload_q;
            A_COUNT:  rd_mux = count_q;
            A_CTRL:   begin
                rd_mux[CTRL_RUN] = run_q;
                rd_mux[CTRL_IE]  = ie_q;
                rd_mux[CTRL_WD]  = wd_q;
            end
            A_STATUS: rd_mux[0] = evt_q;
            A_BOOT:   rd_mux[0] = boot_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

    // R9: watchdog mode only falls through a completed unlock
    p_mode_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_q) |-> $past(unlock));

    // R11: a control write with the mode bit clear keeps watchdog mode
    p_mode_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[CTRL_WD] && wd_q) |=> wd_q);

    // R6: the reset request only follows a cycle in watchdog mode
    p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> $past(wd_q && run_q));

    // R6: the event flag never rises in watchdog mode
    p_no_evt_in_wd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q && !evt_q) |=> !evt_q);
endmodule

// File: tb/tb_wdt_dual_mode.sv
module tb_wdt_dual_mode;
    localparam logic [31:0] K1 = 32'h1234_5678;
    localparam logic [31:0] K2 = 32'h8765_4321;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, wdt_rst_o;

    int n_checks = 0, n_fail = 0, pulses = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    wdt_dual_mode dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    // behavioural reference model
    logic [31:0] m_load, m_cnt, m_rd;
    bit m_run, m_ie, m_wd, m_ev, m_rf, m_rst, m_armed;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {29'd0, m_wd, m_ie, m_run};
            3'd3: return {31'd0, m_ev};
            3'd4: return {31'd0, m_rf};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit zero;
        logic [31:0] n_rd;
        if (!por_n || !sys_rst_n) begin
            m_load = 0; m_cnt = 0; m_rd = 0;
            m_run = 0; m_ie = 0; m_wd = 0; m_ev = 0; m_rst = 0; m_armed = 0;
            if (!por_n) m_rf = 0;
        end else begin
            zero = m_run && (m_cnt == 0);
            n_rd = rd_en ? m_read(rd_addr) : m_rd;
            m_rst = zero && m_wd;
            if (wr_en && wr_addr == 3'd3 && wr_data[0]) m_ev = 0;
            if (zero && !m_wd) m_ev = 1;
            if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_rf = 0;
            if (zero && m_wd) m_rf = 1;
            if (wr_en && wr_addr == 3'd0) begin m_load = wr_data; m_cnt = wr_data; end
            else if (wr_en && wr_addr == 3'd1) m_cnt = wr_data;
            else if (zero) m_cnt = m_load;
            else if (m_run) m_cnt = m_cnt - 1;
            if (wr_en && wr_addr == 3'd2) begin
                m_run = wr_data[0]; m_ie = wr_data[1];
                if (wr_data[2]) m_wd = 1;
            end
            if (wr_en) begin
                if (wr_addr == 3'd5 && m_armed && wr_data == K2) m_wd = 0;
                m_armed = !m_armed && wr_addr == 3'd5 && wr_data == K1;
            end
            m_rd = n_rd;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 rd_data vs model", rd_data, m_rd);
            check("R4 irq_o vs model", {31'd0, irq_o}, {31'd0, m_ie && m_ev});
            check("R6 wdt_rst_o vs model", {31'd0, wdt_rst_o}, {31'd0, m_rst});
            if (wdt_rst_o) pulses++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1; rd_addr = a;
        @(posedge clk); #2;
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got hung expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        por_n = 0;
        repeat (2) @(posedge clk);
        #2 por_n = 1;
        cmp_on = 1;
        // R1 reset state
        check("R1 irq_o after reset", {31'd0, irq_o}, 0);
        check("R1 wdt_rst_o after reset", {31'd0, wdt_rst_o}, 0);
        rd(3'd2, v); check("R1 CTRL after reset", v, 0);
        rd(3'd1, v); check("R1 COUNT after reset", v, 0);

        // R2 counting
        wr(3'd0, 9);
        rd(3'd1, v); check("R2 COUNT after reload write", v, 9);
        wr(3'd2, 1);
        rd(3'd1, v); check("R2 first read while running", v, 9);
        rd(3'd1, v); check("R2 decrement by one", v, 8);
        wr(3'd1, 3);
        rd(3'd1, v); check("R2 COUNT write", v, 3);

        // R3 / R4 timer event and interrupt
        wr(3'd0, 5); wr(3'd2, 3);
        idle(10);
        rd(3'd3, v); check("R3 event flag in STATUS bit0", v, 1);
        check("R4 irq_o with enable", {31'd0, irq_o}, 1);
        wr(3'd2, 1);
        check("R4 irq_o masked", {31'd0, irq_o}, 0);
        // R5 write-one-to-clear
        wr(3'd3, 0);
        rd(3'd3, v); check("R5 writing 0 keeps flag", v, 1);
        wr(3'd2, 0); wr(3'd3, 1);
        rd(3'd3, v); check("R5 writing 1 clears flag", v, 0);
        // R5 collision: clear lands on the zero edge
        wr(3'd0, 20); wr(3'd2, 1); wr(3'd1, 1); idle(1); wr(3'd3, 1);
        rd(3'd3, v); check("R5 set wins over clear", v, 1);
        wr(3'd2, 0); wr(3'd3, 1);

        // R6 / R7 watchdog timeout
        wr(3'd0, 4);
        pulses = 0;
        wr(3'd2, 5);
        idle(7);
        wr(3'd2, 4);
        check("R6 single one-cycle pulse", pulses, 1);
        rd(3'd3, v); check("R6 event flag untouched", v, 0);
        rd(3'd4, v); check("R7 reset flag set", v, 1);
        wr(3'd4, 0);
        rd(3'd4, v); check("R7 writing 0 keeps reset flag", v, 1);

        // R8 system reset keeps the reset flag
        sys_rst_n = 0; idle(2); sys_rst_n = 1;
        rd(3'd4, v); check("R8 reset flag survives system reset", v, 1);
        rd(3'd2, v); check("R8 CTRL cleared by system reset", v, 0);
        wr(3'd4, 1);
        rd(3'd4, v); check("R7 writing 1 clears reset flag", v, 0);
        // R7 collision
        wr(3'd0, 20); wr(3'd2, 5); wr(3'd1, 1); idle(1); wr(3'd4, 1);
        wr(3'd2, 4);
        rd(3'd4, v); check("R7 set wins over clear", v, 1);

        // R9 / R10 / R11 mode control
        wr(3'd2, 0);
        rd(3'd2, v); check("R11 mode bit 0 ignored", v, 4);
        wr(3'd5, K1); wr(3'd5, K1 ^ 32'd1);
        rd(3'd2, v); check("R10 wrong second key", v, 4);
        wr(3'd5, K1); wr(3'd0, 20); wr(3'd5, K2);
        rd(3'd2, v); check("R10 intervening write cancels", v, 4);
        wr(3'd5, K2);
        rd(3'd2, v); check("R10 lone second key", v, 4);
        wr(3'd5, K1); wr(3'd5, K2);
        rd(3'd2, v); check("R9 unlock clears mode", v, 0);
        wr(3'd2, 4);
        rd(3'd2, v); check("R11 mode bit 1 sets mode", v, 4);
        wr(3'd5, K1); idle(2); wr(3'd5, K2);
        rd(3'd2, v); check("R9 idle cycles between keys", v, 0);
        wr(3'd5, K2);
        rd(3'd2, v); check("R9 unlock state cleared after success", v, 0);

        // R8 power-on reset clears the reset flag
        por_n = 0; idle(2); por_n = 1;
        rd(3'd4, v); check("R8 power-on clears reset flag", v, 0);
        idle(2);
        finish_run();
    end
endmodule